// File: doc/BRIEF.md
# Table-Driven Two-Road Junction Light Sequencer

This block sequences the lamps of a crossing between a north road and an east road. It is a Moore machine with four phases. Each phase owns three things: a six-lamp pattern, a dwell length counted in seconds, and a successor list with four entries. The successor is chosen by the value of two car detectors. The pattern is driven for the whole phase. A dwell counter counts down on pulses of an external one-second strobe. On the strobe that ends the dwell, the detector pair is read and the matching successor is taken.

The successor list is a constant look-up indexed by the phase and the detector pair. The dwell length of each phase is a parameter. A new dwell is loaded whenever a phase is entered, and this includes a phase that is its own successor. The detector inputs are asynchronous, so they pass through a two-flop synchronizer before they are used. The block has no data stream: every pin is a plain level or strobe, with no valid/ready handshake and no back-pressure. The strobe source sits outside the block.

Top module: `junction_ctrl`

## Requirements
- R1: While `rst_n` is low and right after it is released, the phase is north-go and `lamps` reads 0x21.
- R2: The lamp pattern on `lamps[5:0]` depends only on the phase: north-go 0x21, north-amber 0x22, east-go 0x0C, east-amber 0x14. Bits 5..3 are the east red, amber and green lamps. Bits 2..0 are the north red, amber and green lamps. Exactly one lamp per road is lit.
- R3: With the default parameters, a phase lasts exactly as many `tick` pulses as its dwell: north-go 30, north-amber 5, east-go 30, east-amber 5.
- R4: When north-go ends, `sense[0]` decides the successor: 1 goes to north-amber, 0 stays in north-go. `sense[1]` is ignored.
- R5: When east-go ends, `sense[1]` decides the successor: 1 goes to east-amber, 0 stays in east-go. `sense[0]` is ignored.
- R6: North-amber always moves to east-go, and east-amber always moves to north-go, whatever `sense` is.
- R7: `sense` is used only at the pulse that ends a dwell, and it is taken through a two-flop synchronizer. A value that is present mid-dwell and removed at least three clocks before the final pulse has no effect.
- R8: Entering a phase loads its full dwell. This also holds when a phase is re-entered from itself.
- R9: `lamps` changes only on the clock edge that samples a `tick` pulse. Clocks with `tick` low leave it unchanged.
- R10: A `tick` that arrives while `rst_n` is low is ignored. After release, north-go still lasts its full 30 pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock strobe, once per second |
| sense | input | 2 | Car detectors: bit 0 decides north-go, bit 1 decides east-go |
| lamps | output | 6 | Lamp pattern, east R/A/G on bits 5..3, north R/A/G on bits 2..0 |

## Verification
The properties assume that `tick` is a single-clock strobe. They also assume that every dwell parameter is at least one, so the countdown never rests at zero. The successor properties are written against the synchronized detector copy, so they assume nothing about when `sense` changes. The stimulus keeps `tick` to one-clock pulses with idle clocks between them. It changes `sense` only at a falling edge and holds it for three clocks before a pulse that is meant to sample it.

// File: rtl/jc_pkg.sv
package jc_pkg;
  typedef enum logic [1:0] {
    PH_N_GO  = 2'd0,
    PH_N_AMB = 2'd1,
    PH_E_GO  = 2'd2,
    PH_E_AMB = 2'd3
  } phase_t;

  localparam int LAMP_W = 6;
  localparam int SENS_W = 2;
  localparam int PHASES = 4;
endpackage

// File: rtl/jc_sync.sv
module jc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/jc_table.sv
module jc_table
  import jc_pkg::*;
#(
  parameter int DW_N_GO  = 30,
  parameter int DW_N_AMB = 5,
  parameter int DW_E_GO  = 30,
  parameter int DW_E_AMB = 5,
  parameter int CNT_W    = 5
) (
  input  phase_t             cur,
  input  logic [SENS_W-1:0]  sens,
  output phase_t             nxt,
  output logic [LAMP_W-1:0]  lamp,
  output logic [CNT_W-1:0]   nxt_dwell
);
  localparam int IDX_W = $bits(phase_t) + SENS_W;
  localparam int ENTRIES = 1 << IDX_W;

  // successor look-up, entry index = {phase, sensors}, highest index first
  localparam logic [ENTRIES-1:0][1:0] SUCC = {
    2'd0, 2'd0, 2'd0, 2'd0,   // east-amber: always north-go
    2'd3, 2'd3, 2'd2, 2'd2,   // east-go: sensor bit 1 selects amber
    2'd2, 2'd2, 2'd2, 2'd2,   // north-amber: always east-go
    2'd1, 2'd0, 2'd1, 2'd0    // north-go: sensor bit 0 selects amber
  };

  logic [IDX_W-1:0] idx;
  assign idx = {cur, sens};
  assign nxt = phase_t'(SUCC[idx]);

  always_comb begin
    unique case (cur)
      PH_N_GO:  lamp = 6'h21;
      PH_N_AMB: lamp = 6'h22;
      PH_E_GO:  lamp = 6'h0C;
      default:  lamp = 6'h14;
    endcase
  end

  always_comb begin
    unique case (nxt)
      PH_N_GO:  nxt_dwell = CNT_W'(DW_N_GO);
      PH_N_AMB: nxt_dwell = CNT_W'(DW_N_AMB);
      PH_E_GO:  nxt_dwell = CNT_W'(DW_E_GO);
      default:  nxt_dwell = CNT_W'(DW_E_AMB);
    endcase
  end
endmodule

// File: rtl/jc_dwell.sv
module jc_dwell #(
  parameter int CNT_W = 5,
  parameter int INIT  = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload,
  output logic             last,
  output logic [CNT_W-1:0] remain
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= CNT_W'(INIT);
    else if (tick) begin
      if (last)         cnt <= reload;
      else              cnt <= cnt - 1'b1;
    end
  end

  assign last   = (cnt == CNT_W'(1));
  assign remain = cnt;
endmodule

// File: rtl/junction_ctrl.sv
module junction_ctrl
  import jc_pkg::*;
#(
  parameter int DW_N_GO  = 30,
  parameter int DW_N_AMB = 5,
  parameter int DW_E_GO  = 30,
  parameter int DW_E_AMB = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] sense,
  output logic [5:0] lamps
);
  localparam int DW_MAX_G = (DW_N_GO > DW_E_GO) ? DW_N_GO : DW_E_GO;
  localparam int DW_MAX_A = (DW_N_AMB > DW_E_AMB) ? DW_N_AMB : DW_E_AMB;
  localparam int DW_MAX   = (DW_MAX_G > DW_MAX_A) ? DW_MAX_G : DW_MAX_A;
  localparam int CNT_W    = $clog2(DW_MAX + 1);

  phase_t             phase, phase_nxt;
  logic [SENS_W-1:0]  sens_s;
  logic [CNT_W-1:0]   reload, remain;
  logic               dwell_end;

  jc_sync #(.W(SENS_W), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(sense), .q(sens_s)
  );

  jc_table #(
    .DW_N_GO(DW_N_GO), .DW_N_AMB(DW_N_AMB),
    .DW_E_GO(DW_E_GO), .DW_E_AMB(DW_E_AMB), .CNT_W(CNT_W)
  ) u_table (
    .cur(phase), .sens(sens_s), .nxt(phase_nxt),
    .lamp(lamps), .nxt_dwell(reload)
  );

  jc_dwell #(.CNT_W(CNT_W), .INIT(DW_N_GO)) u_dwell (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reload(reload),
    .last(dwell_end), .remain(remain)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  phase <= PH_N_GO;
    else if (tick && dwell_end)  phase <= phase_nxt;
  end
endmodule

// File: rtl/jc_chk.sv
module jc_chk #(
  parameter int CNT_W    = 5,
  parameter int DW_N_GO  = 30,
  parameter int DW_N_AMB = 5,
  parameter int DW_E_GO  = 30,
  parameter int DW_E_AMB = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [1:0]       sens_s,
  input logic [5:0]       lamps,
  input logic [CNT_W-1:0] remain
);
  logic fin;
  assign fin = tick && (remain == CNT_W'(1));

  AST_ONE_LAMP_PER_ROAD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(lamps[2:0]) && $onehot(lamps[5:3])); // R2
  AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    remain != '0); // R3
  AST_NGO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && lamps == 6'h21 && !sens_s[0]) |=> lamps == 6'h21); // R4
  AST_NGO_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && lamps == 6'h21 && sens_s[0]) |=> lamps == 6'h22); // R4
  AST_EGO_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && lamps == 6'h0C && sens_s[1]) |=> lamps == 6'h14); // R5
  AST_NAMB_TO_EGO: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && lamps == 6'h22) |=> lamps == 6'h0C); // R6
  AST_EAMB_TO_NGO: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && lamps == 6'h14) |=> lamps == 6'h21); // R6
  AST_FULL_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (remain == CNT_W'(DW_N_GO) || remain == CNT_W'(DW_N_AMB) ||
             remain == CNT_W'(DW_E_GO) || remain == CNT_W'(DW_E_AMB))); // R8
  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(lamps)); // R9
endmodule

bind junction_ctrl jc_chk #(
  .CNT_W(CNT_W), .DW_N_GO(DW_N_GO), .DW_N_AMB(DW_N_AMB),
  .DW_E_GO(DW_E_GO), .DW_E_AMB(DW_E_AMB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .sens_s(sens_s),
  .lamps(lamps), .remain(remain)
);

// File: tb/tb_junction_ctrl.sv
module tb_junction_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] sense = 2'b00;
  logic [5:0] lamps;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  junction_ctrl dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sense(sense), .lamps(lamps)
  );

  localparam int NV = 14;
  localparam logic [1:0] V_SENS  [NV] = '{2'b00, 2'b00, 2'b10, 2'b01, 2'b01, 2'b00, 2'b00,
                                          2'b01, 2'b10, 2'b11, 2'b11, 2'b11, 2'b11, 2'b00};
  localparam int         V_TICKS [NV] = '{29, 1, 30, 29, 1, 4, 1, 30, 30, 5, 30, 5, 30, 5};
  localparam logic [5:0] V_LAMP  [NV] = '{6'h21, 6'h21, 6'h21, 6'h21, 6'h22, 6'h22, 6'h0C,
                                          6'h0C, 6'h14, 6'h21, 6'h22, 6'h0C, 6'h14, 6'h21};

  task automatic check(input string req, input logic [5:0] got, input logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s lamps got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic set_sense(input logic [1:0] v);
    @(negedge clk) sense = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit held;
    logic [5:0] snap;
    repeat (3) @(negedge clk);
    check("R1 during reset", lamps, 6'h21);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", lamps, 6'h21);

    // table walk: R2 R3 R4 R5 R6 R8
    for (int v = 0; v < NV; v++) begin
      set_sense(V_SENS[v]);
      pulses(V_TICKS[v]);
      check($sformatf("R2/R3/R4/R5/R6/R8 vector %0d", v), lamps, V_LAMP[v]);
    end

    // R7: detector active mid-dwell, withdrawn before the final pulse
    set_sense(2'b01);
    pulses(20);
    set_sense(2'b00);
    pulses(10);
    check("R7 mid-dwell detector ignored", lamps, 6'h21);

    // R8: the re-entry just made must give a full 30-pulse dwell
    set_sense(2'b01);
    pulses(29);
    check("R8 reloaded dwell not yet over", lamps, 6'h21);
    pulses(1);
    check("R8 reloaded dwell ends on pulse 30", lamps, 6'h22);

    // R9: no pulses, lamps must hold
    held = 1'b1;
    snap = lamps;
    for (int c = 0; c < 50; c++) begin
      @(negedge clk);
      if (lamps !== snap) held = 1'b0;
    end
    check("R9 hold without tick", held ? snap : lamps, snap);

    // R10 and R1: reset from east-go with strobes present
    pulses(5);
    check("R6 amber to east-go", lamps, 6'h0C);
    @(negedge clk) rst_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
    check("R1 reset from east-go", lamps, 6'h21);
    @(negedge clk) rst_n = 1'b1;
    set_sense(2'b01);
    pulses(29);
    check("R10 reset-time ticks ignored", lamps, 6'h21);
    pulses(1);
    check("R10 full dwell after reset", lamps, 6'h22);

    // R5 with only bit 0 set: east-go must stay
    pulses(5);
    set_sense(2'b01);
    pulses(30);
    check("R5 sense[0] ignored in east-go", lamps, 6'h0C);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule